// File: doc/BRIEF.md
# Mailbox Status Merge Engine

This block sits in an I/O port between the link to a downstream adapter and a system memory bus that supports bank locking. The port first registers each outgoing mailbox command: its 32-bit command word and the memory address of its mailbox structure. When the adapter later returns a status packet for that command, the engine accepts the packet. It fetches the mailbox line with a locked read, folds the status fields into the line and releases the lock with an unlocking write to the same address. The locked read followed by the unlocking write keeps the update atomic against other bus masters.

The merge is selective. The adapter's return data replaces bits 31:0 only when the pending command was a read. The device-specific field, the error flag and the done flag are always written. Every other bit goes back exactly as memory returned it. The unlocking write uses the top-priority request line when the port is configured as node 8, and uses the port's own node line otherwise.

The port can also detect a fault itself: an error flagged on the read response, or no response within a programmable number of cycles. In either case the engine records the first fault's cause and address in a log that holds until software clears it, and it pulses an interrupt. The bus lock is then left for recovery software, and no write-back is issued.

The sequencer has seven states:
- IDLE accepts a packet and moves to ISSUE_LOCK_READ.
- ISSUE_LOCK_READ moves to WAIT_READ_DATA on grant.
- WAIT_READ_DATA moves to MERGE on good data, or to DONE on a response error or a timeout.
- MERGE moves to ISSUE_UNLOCK_WRITE.
- ISSUE_UNLOCK_WRITE moves to WAIT_WRITE_ACK on grant.
- WAIT_WRITE_ACK moves to DONE on acknowledge.
- DONE returns to IDLE.

Top module: `mbx_status_merge`

## Requirements
- R1: `sts_ready` is high only in IDLE. A packet is taken on a cycle with `sts_valid` and `sts_ready` both high, and `sts_ready` stays low until that packet's sequence has finished.
- R2: Each accepted packet produces exactly one locked read (`bus_req_cmd` = 1) of the mailbox address registered with the last `cmd_fire`. On a good read response it is followed by exactly one unlocking write (`bus_req_cmd` = 2) of that same address. A request holds its command and address until `bus_gnt`.
- R3: The written line sets bits 47:32 to the packet's device field, bit 62 to the packet's error flag and bit 63 to 1. All other bits equal the locked-read data, apart from bits 31:0, which R4 governs.
- R4: Bits 31:0 take the packet's return data only if the pending command word equals 32'h0000_0001 (read). For any other command they keep the value memory returned.
- R5: `bus_req_line` is one-hot while a request is pending and zero otherwise. The locked read uses bit `cfg_node`. The unlocking write uses bit 16 when `cfg_node` is 8, and bit `cfg_node` otherwise.
- R6: A read response with `bus_rd_err` set logs cause 1, issues no write and pulses `err_irq` for exactly one cycle.
- R7: If no read response arrives while the wait counter runs from 0 up to `cfg_timeout`, the engine logs cause 2, issues no write and pulses `err_irq`. With the engine's register stages counted, the pulse appears `cfg_timeout`+2 cycles after the grant cycle.
- R8: The log (`err_log_valid`, cause, address) keeps the first fault and ignores later faults until a cycle with `err_clr` high clears it.
- R9: After reset, `sts_ready` is 1 and `bus_req_valid`, `err_irq` and `err_log_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_node | input | NODE_W | Node number of this port |
| cfg_timeout | input | TMO_W | Read-response timeout limit in cycles |
| cmd_fire | input | 1 | Registers a mailbox command being sent downstream |
| cmd_word | input | 32 | Command field of that command |
| cmd_mbx_addr | input | ADDR_W | Memory address of its mailbox structure |
| sts_valid | input | 1 | Status packet valid |
| sts_ready | output | 1 | Engine can take a status packet |
| sts_data | input | 32 | Return data of the status packet |
| sts_dev | input | 16 | Device-specific field of the status packet |
| sts_err | input | 1 | Adapter-reported error flag |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 1 = locked read, 2 = unlocking write |
| bus_req_line | output | NUM_NODES+1 | One-hot request identity; bit 16 is the top-priority line |
| bus_addr | output | ADDR_W | Mailbox address of the request |
| bus_wdata | output | 64 | Merged line for the unlocking write |
| bus_gnt | input | 1 | Bus accepts the pending request |
| bus_rd_valid | input | 1 | Read response valid |
| bus_rd_data | input | 64 | Read response line |
| bus_rd_err | input | 1 | Read response carries an error |
| bus_wr_ack | input | 1 | Write completed |
| err_clr | input | 1 | Write-one-to-clear for the error log |
| err_log_valid | output | 1 | Error log holds a fault |
| err_log_cause | output | 2 | 1 = read response error, 2 = timeout |
| err_log_addr | output | ADDR_W | Mailbox address of the logged fault |
| err_irq | output | 1 | One-cycle error interrupt pulse |

## Verification
The checker checks these properties on every cycle:
- `sts_ready` and a bus request are never high together.
- A request holds its command and address until it is granted.
- The request line is one-hot, and the write-back uses bit 16 for node 8.
- Every written line has the done bit set.
- The interrupt is a single-cycle pulse, and the log is set whenever it fires.
- A logged fault holds until it is cleared.

The bench's scenarios cover the properties that need a memory model:
- the exact merged contents for read and non-read commands;
- that exactly one read and at most one write happen per packet;
- that no write follows a port-detected fault;
- the timeout latency;
- that the log keeps the first fault over a later one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int LINE_W    = 64;
    localparam int RDATA_W   = 32;
    localparam int DEV_LSB   = 32;
    localparam int DEV_W     = 16;
    localparam int ERR_BIT   = 62;
    localparam int DONE_BIT  = 63;
    localparam logic [31:0] CMD_READ = 32'h0000_0001;

    typedef enum logic [1:0] {
        BUS_NONE      = 2'd0,
        BUS_LOCK_RD   = 2'd1,
        BUS_UNLOCK_WR = 2'd2
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_RD_ERR  = 2'd1,
        CAUSE_TIMEOUT = 2'd2
    } err_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LOCK_READ,
        ST_WAIT_READ_DATA,
        ST_MERGE,
        ST_ISSUE_UNLOCK_WRITE,
        ST_WAIT_WRITE_ACK,
        ST_DONE
    } mbx_state_e;
endpackage

// File: rtl/mbx_seq_fsm.sv
module mbx_seq_fsm
    import mbx_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sts_valid,
    input  logic              bus_gnt,
    input  logic              bus_rd_valid,
    input  logic              bus_rd_err,
    input  logic              bus_wr_ack,
    input  logic [TMO_W-1:0]  cfg_timeout,
    output logic              sts_ready,
    output logic              accept,
    output logic              req_valid,
    output bus_cmd_e          req_cmd,
    output logic              line_load,
    output logic              merge_en,
    output logic              err_event,
    output err_cause_e        err_cause
);
    mbx_state_e       state_q, state_d;
    logic [TMO_W-1:0] tmo_q;
    logic             tmo_hit;

    assign tmo_hit = (tmo_q >= cfg_timeout);

    // state register and wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            tmo_q   <= (state_q == ST_WAIT_READ_DATA) ? tmo_q + 1'b1 : '0;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:               if (sts_valid) state_d = ST_ISSUE_LOCK_READ;
            ST_ISSUE_LOCK_READ:    if (bus_gnt) state_d = ST_WAIT_READ_DATA;
            ST_WAIT_READ_DATA: begin
                if (bus_rd_valid)  state_d = bus_rd_err ? ST_DONE : ST_MERGE;
                else if (tmo_hit)  state_d = ST_DONE;
            end
            ST_MERGE:              state_d = ST_ISSUE_UNLOCK_WRITE;
            ST_ISSUE_UNLOCK_WRITE: if (bus_gnt) state_d = ST_WAIT_WRITE_ACK;
            ST_WAIT_WRITE_ACK:     if (bus_wr_ack) state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sts_ready = 1'b0;
        accept    = 1'b0;
        req_valid = 1'b0;
        req_cmd   = BUS_NONE;
        line_load = 1'b0;
        merge_en  = 1'b0;
        err_event = 1'b0;
        err_cause = CAUSE_NONE;
        unique case (state_q)
            ST_IDLE: begin
                sts_ready = 1'b1;
                accept    = sts_valid;
            end
            ST_ISSUE_LOCK_READ: begin
                req_valid = 1'b1;
                req_cmd   = BUS_LOCK_RD;
            end
            ST_WAIT_READ_DATA: begin
                if (bus_rd_valid && !bus_rd_err) begin
                    line_load = 1'b1;
                end else if (bus_rd_valid) begin
                    err_event = 1'b1;
                    err_cause = CAUSE_RD_ERR;
                end else if (tmo_hit) begin
                    err_event = 1'b1;
                    err_cause = CAUSE_TIMEOUT;
                end
            end
            ST_MERGE: merge_en = 1'b1;
            ST_ISSUE_UNLOCK_WRITE: begin
                req_valid = 1'b1;
                req_cmd   = BUS_UNLOCK_WR;
            end
            ST_WAIT_WRITE_ACK, ST_DONE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/mbx_merge_dp.sv
module mbx_merge_dp
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_NODES = 16,
    parameter int HIGH_NODE = 8,
    parameter int NODE_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_fire,
    input  logic [31:0]          cmd_word,
    input  logic [ADDR_W-1:0]    cmd_mbx_addr,
    input  logic                 accept,
    input  logic [RDATA_W-1:0]   sts_data,
    input  logic [DEV_W-1:0]     sts_dev,
    input  logic                 sts_err,
    input  logic                 line_load,
    input  logic [LINE_W-1:0]    rd_data,
    input  logic                 merge_en,
    input  logic                 req_valid,
    input  bus_cmd_e             req_cmd,
    input  logic [NODE_W-1:0]    cfg_node,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [LINE_W-1:0]    bus_wdata,
    output logic [NUM_NODES:0]   req_line
);
    logic                pend_read_q, cur_read_q;
    logic [ADDR_W-1:0]   pend_addr_q, cur_addr_q;
    logic [RDATA_W-1:0]  pk_data_q;
    logic [DEV_W-1:0]    pk_dev_q;
    logic                pk_err_q;
    logic [LINE_W-1:0]   line_q, wdata_q, merged;
    logic                use_high;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_read_q <= 1'b0;
            pend_addr_q <= '0;
            cur_read_q  <= 1'b0;
            cur_addr_q  <= '0;
            pk_data_q   <= '0;
            pk_dev_q    <= '0;
            pk_err_q    <= 1'b0;
            line_q      <= '0;
            wdata_q     <= '0;
        end else begin
            if (cmd_fire) begin
                pend_read_q <= (cmd_word == CMD_READ);
                pend_addr_q <= cmd_mbx_addr;
            end
            if (accept) begin
                cur_read_q <= pend_read_q;
                cur_addr_q <= pend_addr_q;
                pk_data_q  <= sts_data;
                pk_dev_q   <= sts_dev;
                pk_err_q   <= sts_err;
            end
            if (line_load) line_q  <= rd_data;
            if (merge_en)  wdata_q <= merged;
        end
    end

    always_comb begin
        merged = line_q;
        if (cur_read_q) merged[RDATA_W-1:0] = pk_data_q;
        merged[DEV_LSB +: DEV_W] = pk_dev_q;
        merged[ERR_BIT]          = pk_err_q;
        merged[DONE_BIT]         = 1'b1;
    end

    assign bus_addr  = cur_addr_q;
    assign bus_wdata = wdata_q;
    assign use_high  = (req_cmd == BUS_UNLOCK_WR) && (cfg_node == NODE_W'(HIGH_NODE));

    for (genvar g = 0; g < NUM_NODES; g++) begin : g_line
        assign req_line[g] = req_valid && !use_high && (cfg_node == NODE_W'(g));
    end
    assign req_line[NUM_NODES] = req_valid && use_high;
endmodule

// File: rtl/mbx_err_log.sv
module mbx_err_log
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_event,
    input  err_cause_e        err_cause,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              err_clr,
    output logic              log_valid,
    output logic [1:0]        log_cause,
    output logic [ADDR_W-1:0] log_addr,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_valid <= 1'b0;
            log_cause <= '0;
            log_addr  <= '0;
            irq       <= 1'b0;
        end else begin
            irq <= err_event;
            if (err_event && (!log_valid || err_clr)) begin
                log_valid <= 1'b1;
                log_cause <= err_cause;
                log_addr  <= err_addr;
            end else if (err_clr) begin
                log_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mbx_status_merge.sv
module mbx_status_merge
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_NODES = 16,
    parameter int HIGH_NODE = 8,
    parameter int TMO_W     = 16,
    localparam int NODE_W   = $clog2(NUM_NODES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NODE_W-1:0]    cfg_node,
    input  logic [TMO_W-1:0]     cfg_timeout,
    input  logic                 cmd_fire,
    input  logic [31:0]          cmd_word,
    input  logic [ADDR_W-1:0]    cmd_mbx_addr,
    input  logic                 sts_valid,
    output logic                 sts_ready,
    input  logic [31:0]          sts_data,
    input  logic [15:0]          sts_dev,
    input  logic                 sts_err,
    output logic                 bus_req_valid,
    output logic [1:0]           bus_req_cmd,
    output logic [NUM_NODES:0]   bus_req_line,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [63:0]          bus_wdata,
    input  logic                 bus_gnt,
    input  logic                 bus_rd_valid,
    input  logic [63:0]          bus_rd_data,
    input  logic                 bus_rd_err,
    input  logic                 bus_wr_ack,
    input  logic                 err_clr,
    output logic                 err_log_valid,
    output logic [1:0]           err_log_cause,
    output logic [ADDR_W-1:0]    err_log_addr,
    output logic                 err_irq
);
    logic       accept, line_load, merge_en, err_event;
    bus_cmd_e   req_cmd;
    err_cause_e err_cause;

    mbx_seq_fsm #(.TMO_W(TMO_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .sts_valid(sts_valid), .bus_gnt(bus_gnt),
        .bus_rd_valid(bus_rd_valid), .bus_rd_err(bus_rd_err), .bus_wr_ack(bus_wr_ack),
        .cfg_timeout(cfg_timeout), .sts_ready(sts_ready), .accept(accept),
        .req_valid(bus_req_valid), .req_cmd(req_cmd), .line_load(line_load),
        .merge_en(merge_en), .err_event(err_event), .err_cause(err_cause)
    );

    mbx_merge_dp #(.ADDR_W(ADDR_W), .NUM_NODES(NUM_NODES), .HIGH_NODE(HIGH_NODE),
                   .NODE_W(NODE_W)) i_dp (
        .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_word(cmd_word),
        .cmd_mbx_addr(cmd_mbx_addr), .accept(accept), .sts_data(sts_data),
        .sts_dev(sts_dev), .sts_err(sts_err), .line_load(line_load),
        .rd_data(bus_rd_data), .merge_en(merge_en), .req_valid(bus_req_valid),
        .req_cmd(req_cmd), .cfg_node(cfg_node), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .req_line(bus_req_line)
    );

    mbx_err_log #(.ADDR_W(ADDR_W)) i_log (
        .clk(clk), .rst_n(rst_n), .err_event(err_event), .err_cause(err_cause),
        .err_addr(bus_addr), .err_clr(err_clr), .log_valid(err_log_valid),
        .log_cause(err_log_cause), .log_addr(err_log_addr), .irq(err_irq)
    );

    assign bus_req_cmd = req_cmd;
endmodule

// File: rtl/mbx_status_merge_chk.sv
module mbx_status_merge_chk #(
    parameter int ADDR_W    = 32,
    parameter int NUM_NODES = 16,
    parameter int HIGH_NODE = 8,
    parameter int NODE_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NODE_W-1:0]  cfg_node,
    input logic               sts_ready,
    input logic               bus_req_valid,
    input logic [1:0]         bus_req_cmd,
    input logic [NUM_NODES:0] bus_req_line,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [63:0]        bus_wdata,
    input logic               bus_gnt,
    input logic               err_clr,
    input logic               err_log_valid,
    input logic [1:0]         err_log_cause,
    input logic [ADDR_W-1:0]  err_log_addr,
    input logic               err_irq
);
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ready |-> !bus_req_valid); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_gnt |=> bus_req_valid && $stable(bus_addr) && $stable(bus_req_cmd)); // R2
    AST_DONE_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_req_cmd == 2'd2 |-> bus_wdata[63]); // R3
    AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> $countones(bus_req_line) == 1); // R5
    AST_LINE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_valid |-> bus_req_line == '0); // R5
    AST_HIGH_PRIO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_req_cmd == 2'd2 && cfg_node == NODE_W'(HIGH_NODE)
        |-> bus_req_line[NUM_NODES]); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq); // R6
    AST_IRQ_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> err_log_valid); // R8
    AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        err_log_valid && !err_clr |=> err_log_valid && $stable(err_log_cause) && $stable(err_log_addr)); // R8
endmodule

bind mbx_status_merge mbx_status_merge_chk #(
    .ADDR_W(ADDR_W), .NUM_NODES(NUM_NODES), .HIGH_NODE(HIGH_NODE), .NODE_W(NODE_W)
) i_chk (.*);

// File: tb/test_mbx_status_merge.sv
module test_mbx_status_merge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_node = 4'd0;
    logic [15:0] cfg_timeout = 16'd20;
    logic        cmd_fire = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] cmd_mbx_addr = '0;
    logic        sts_valid = 1'b0;
    logic        sts_ready;
    logic [31:0] sts_data = '0;
    logic [15:0] sts_dev = '0;
    logic        sts_err = 1'b0;
    logic        bus_req_valid;
    logic [1:0]  bus_req_cmd;
    logic [16:0] bus_req_line;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic        bus_rd_valid = 1'b0;
    logic [63:0] bus_rd_data = '0;
    logic        bus_rd_err = 1'b0;
    logic        bus_wr_ack = 1'b0;
    logic        err_clr = 1'b0;
    logic        err_log_valid;
    logic [1:0]  err_log_cause;
    logic [31:0] err_log_addr;
    logic        err_irq;

    mbx_status_merge i_mbx_status_merge (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_lock = 0, n_unlock = 0, n_irq = 0, irq_cyc = 0, gnt_cyc = 0;
    int rmode = 0;               // 0 good response, 1 error response, 2 no response
    logic [63:0] mem [int];
    bit rd_pend = 0, wr_pend = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_addr;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mrd(input logic [31:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 64'h0;
    endfunction

    function automatic logic [16:0] exp_line(input logic [1:0] c, input logic [3:0] nd);
        return (c == 2'd2 && nd == 4'd8) ? 17'h1_0000 : (17'h1 << nd);
    endfunction

    always @(posedge clk) cyc++;

    // bus responder and per-cycle reference comparison
    always @(negedge clk) begin
        bus_rd_valid = 1'b0;
        bus_rd_err   = 1'b0;
        bus_wr_ack   = 1'b0;
        if (err_irq) begin n_irq++; irq_cyc = cyc; end
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                bus_rd_valid = 1'b1;
                bus_rd_data  = mrd(rd_addr);
                bus_rd_err   = (rmode == 1);
                rd_pend      = 0;
            end else rd_cnt--;
        end
        if (wr_pend) begin
            if (wr_cnt == 0) begin bus_wr_ack = 1'b1; wr_pend = 0; end
            else wr_cnt--;
        end
        if (bus_req_valid && !bus_gnt) begin
            bus_gnt = 1'b1;
            gnt_cyc = cyc;
            chk(bus_req_line == exp_line(bus_req_cmd, cfg_node), "R5 request line",
                64'(bus_req_line), 64'(exp_line(bus_req_cmd, cfg_node)));
            if (bus_req_cmd == 2'd1) begin
                n_lock++;
                rd_addr = bus_addr;
                if (rmode != 2) begin rd_pend = 1; rd_cnt = 2; end
            end else if (bus_req_cmd == 2'd2) begin
                n_unlock++;
                mem[int'(bus_addr)] = bus_wdata;
                wr_pend = 1; wr_cnt = 1;
            end
        end else begin
            bus_gnt = 1'b0;
        end
    end

    task automatic run_pkt(input logic [31:0] addr, input logic [31:0] cw, input logic [31:0] d,
                           input logic [15:0] dv, input bit e, input int mode);
        int lk0, ul0, w;
        bit busy_ok;
        lk0 = n_lock; ul0 = n_unlock; busy_ok = 1; w = 0;
        rmode = mode;
        @(negedge clk);
        chk(sts_ready == 1'b1, "R1 ready when idle", 64'(sts_ready), 64'h1);
        cmd_fire = 1'b1; cmd_word = cw; cmd_mbx_addr = addr;
        @(negedge clk);
        cmd_fire = 1'b0;
        sts_valid = 1'b1; sts_data = d; sts_dev = dv; sts_err = e;
        @(negedge clk);
        sts_valid = 1'b0;
        while (!sts_ready && w < 2000) begin
            @(negedge clk);
            w++;
        end
        if (w < 3) busy_ok = 0;
        chk(busy_ok, "R1 ready low while busy", 64'(w), 64'd3);
        chk(n_lock - lk0 == 1, "R2 one locked read", 64'(n_lock - lk0), 64'd1);
        chk(n_unlock - ul0 == (mode == 0 ? 1 : 0), "R2 write count",
            64'(n_unlock - ul0), 64'(mode == 0 ? 1 : 0));
    endtask

    function automatic logic [63:0] merge_ref(input logic [63:0] old, input bit isrd,
                                              input logic [31:0] d, input logic [15:0] dv, input bit e);
        logic [63:0] r;
        r = old;
        if (isrd) r[31:0] = d;
        r[47:32] = dv;
        r[62] = e;
        r[63] = 1'b1;
        return r;
    endfunction

    initial begin
        logic [63:0] exp;
        int irq0;
        mem[32'h100] = 64'h3A5A_0F0F_1111_2222;
        mem[32'h200] = 64'h4C00_BEEF_CAFE_F00D;
        mem[32'h300] = 64'h0000_0000_0000_0000;
        mem[32'h400] = 64'h1357_2468_ACE0_BDF1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sts_ready == 1'b1, "R9 reset ready", 64'(sts_ready), 64'h1);
        chk(bus_req_valid == 1'b0, "R9 reset no request", 64'(bus_req_valid), 64'h0);
        chk(err_irq == 1'b0 && err_log_valid == 1'b0, "R9 reset error state",
            64'({err_irq, err_log_valid}), 64'h0);

        // read command, node 3: full merge including return data
        cfg_node = 4'd3;
        exp = merge_ref(mem[32'h100], 1, 32'hDEAD_0001, 16'h5A5A, 0);
        run_pkt(32'h100, 32'h0000_0001, 32'hDEAD_0001, 16'h5A5A, 0, 0);
        chk(mem[32'h100] == exp, "R3 R4 read merge", mem[32'h100], exp);

        // write command, node 8: data field kept, error bit cleared, top-priority line
        cfg_node = 4'd8;
        exp = merge_ref(mem[32'h200], 0, 32'h0, 16'h0102, 0);
        run_pkt(32'h200, 32'h0000_0002, 32'h7777_7777, 16'h0102, 0, 0);
        chk(mem[32'h200] == exp, "R4 non-read keeps data", mem[32'h200], exp);

        // adapter error flag copied, node 15
        cfg_node = 4'd15;
        exp = merge_ref(64'h0, 1, 32'h0BAD_F00D, 16'hFFFF, 1);
        run_pkt(32'h300, 32'h0000_0001, 32'h0BAD_F00D, 16'hFFFF, 1, 0);
        chk(mem[32'h300] == exp, "R3 error flag copied", mem[32'h300], exp);
        chk(n_irq == 0, "R6 no irq for adapter error", 64'(n_irq), 64'h0);

        // read response error, node 0
        cfg_node = 4'd0;
        irq0 = n_irq;
        run_pkt(32'h400, 32'h0000_0001, 32'h1, 16'h1, 0, 1);
        chk(mem[32'h400] == 64'h1357_2468_ACE0_BDF1, "R6 memory untouched",
            mem[32'h400], 64'h1357_2468_ACE0_BDF1);
        chk(n_irq - irq0 == 1, "R6 one irq pulse", 64'(n_irq - irq0), 64'h1);
        chk(err_log_valid && err_log_cause == 2'd1 && err_log_addr == 32'h400, "R6 log content",
            {30'h0, err_log_cause, err_log_addr}, {30'h0, 2'd1, 32'h400});

        // timeout while log holds earlier fault
        cfg_node = 4'd5;
        irq0 = n_irq;
        run_pkt(32'h500, 32'h0000_0001, 32'h2, 16'h2, 0, 2);
        chk(n_irq - irq0 == 1, "R7 timeout irq", 64'(n_irq - irq0), 64'h1);
        chk(irq_cyc - gnt_cyc == 22, "R7 timeout latency", 64'(irq_cyc - gnt_cyc), 64'd22);
        chk(err_log_cause == 2'd1 && err_log_addr == 32'h400, "R8 first fault kept",
            {30'h0, err_log_cause, err_log_addr}, {30'h0, 2'd1, 32'h400});

        // clear, then a fresh timeout is logged
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(err_log_valid == 1'b0, "R8 clear", 64'(err_log_valid), 64'h0);
        cfg_timeout = 16'd5;
        run_pkt(32'h600, 32'h0000_0001, 32'h3, 16'h3, 0, 2);
        chk(irq_cyc - gnt_cyc == 7, "R7 short timeout latency", 64'(irq_cyc - gnt_cyc), 64'd7);
        chk(err_log_valid && err_log_cause == 2'd2 && err_log_addr == 32'h600, "R7 log timeout",
            {30'h0, err_log_cause, err_log_addr}, {30'h0, 2'd2, 32'h600});

        // normal operation resumes, node 8 read
        cfg_node = 4'd8;
        mem[32'h700] = 64'h8000_0000_0000_0000;
        exp = merge_ref(mem[32'h700], 1, 32'h1234_5678, 16'hABCD, 0);
        run_pkt(32'h700, 32'h0000_0001, 32'h1234_5678, 16'hABCD, 0, 0);
        chk(mem[32'h700] == exp, "R3 R4 merge after faults", mem[32'h700], exp);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule